// File: doc/BRIEF.md
# Dual-Mode Host Bus Decoder

This block sits between an 8-bit asynchronous host bus and the register file of a four-channel peripheral. A static mode input selects one of two bus styles. In strobe style the host drives separate active-low read and write strobes and one active-low select per channel. In single-select style the host drives one active-low select, a read/write level, and two address lines that name the channel. In both styles three address lines pick one of eight registers inside the chosen channel.

Every bus pin passes through a two-flop synchronizer into the internal clock domain, and access boundaries are found as edges of the synchronized signals. A write produces one register-write pulse carrying the channel, register address and data byte captured during the access. A read produces one read-enable pulse and drives the data bus from the register file for as long as the read lasts. The channel and register address stay fixed for the whole read.

Top module: `hbus_decoder`

## Requirements
- R1: After reset, `wr_pulse`, `rd_en`, `bus_oe`, `chan`, `reg_addr`, `wr_data` and `bus_dout` are all zero.
- R2: In strobe style (`mode_strobe`=1), a low-then-high pulse on `wr_n_pin` while a channel select is low gives exactly one `wr_pulse`. `chan` equals the selected channel, `reg_addr` equals `addr_pin`, and `wr_data` equals `bus_din`, all as held while the strobe was low.
- R3: In strobe style, holding `rd_n_pin` low while a channel select is low gives one `rd_en` pulse. It also raises `bus_oe`, with `bus_dout` equal to `rd_data` for the addressed channel and register.
- R4: In strobe style, `cs_n_pin[i]` low selects channel i (0=A to 3=D). When several are low, the lowest index wins. When none is low, no strobe causes an access.
- R5: In single-select style (`mode_strobe`=0), `cs_n_pin[0]` is the active-low select, `cs_n_pin[1]` is channel bit 0, `cs_n_pin[2]` is channel bit 1, and `wr_n_pin` is a read/write level (1=read, 0=write). A write commits one `wr_pulse` when `cs_n_pin[0]` rises while the level is 0.
- R6: In single-select style, `cs_n_pin[0]` low with the read/write level at 1 gives one `rd_en` pulse and holds `bus_oe` high with `bus_dout` equal to `rd_data`.
- R7: In single-select style, `rd_n_pin` and `cs_n_pin[3]` have no effect: toggling them causes no access and does not change a write's result.
- R8: Each access yields exactly one pulse; `wr_pulse` and `rd_en` never stay high for two consecutive cycles.
- R9: `bus_oe` is high only during a read. It falls, and `bus_dout` returns to zero, within four clock cycles of the read ending at the pins.
- R10: While `bus_oe` stays high, `chan` and `reg_addr` keep the values captured at the start of the read, even if the address pins change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_strobe | input | 1 | Static bus style: 1 strobe style, 0 single-select style |
| rd_n_pin | input | 1 | Active-low read strobe (strobe style only) |
| wr_n_pin | input | 1 | Write strobe, or read/write level in single-select style |
| cs_n_pin | input | 4 | Per-channel selects, or select plus channel bits |
| addr_pin | input | 3 | Register address within a channel |
| bus_din | input | 8 | Data bus as seen from the host |
| rd_data | input | 8 | Read data from the register file for `chan`/`reg_addr` |
| bus_dout | output | 8 | Data driven toward the host during a read |
| bus_oe | output | 1 | Output enable for the bidirectional data bus |
| chan | output | 2 | Channel index of the current access |
| reg_addr | output | 3 | Register address of the current access |
| wr_pulse | output | 1 | One-cycle register write strobe |
| wr_data | output | 8 | Byte to write, valid with `wr_pulse` |
| rd_en | output | 1 | One-cycle read enable at the start of a read |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus, three register address bits, four channels, two synchronizer stages, and single-select support enabled. With four channels, every priority outcome among the strobe-style selects can be reached, including the case where no select is low. All four channel encodings are also reachable through the two single-select address bits. Random accesses in both styles are mixed with directed cases: address pins changing during a read, unused pins toggling in single-select style, and release of the bus enable after a read.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

   typedef enum logic {
      HB_STYLE_SINGLE = 1'b0,
      HB_STYLE_STROBE = 1'b1
   } hb_style_e;

   localparam int unsigned HB_DEF_DATA_W = 8;
   localparam int unsigned HB_DEF_ADDR_W = 3;
   localparam int unsigned HB_DEF_NUM_CH = 4;
   localparam int unsigned HB_DEF_SYNC   = 2;

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/hbus_chan_dec.sv
module hbus_chan_dec #(
   parameter int unsigned NUM_CH     = 4,
   parameter int unsigned CH_W       = 2,
   parameter bit          HAS_SINGLE = 1'b1
) (
   input  logic              mode_strobe,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [NUM_CH-1:0] cs_n,
   output logic              rd_act,
   output logic              wr_act,
   output logic [CH_W-1:0]   chan
);

   logic            pri_hit;
   logic [CH_W-1:0] pri_ch;
   logic            p_rd;
   logic            p_wr;

   // lowest index wins: scan downward so the last hit is the lowest
   always_comb begin
      pri_hit = 1'b0;
      pri_ch  = '0;
      for (int i = int'(NUM_CH) - 1; i >= 0; i--) begin
         if (!cs_n[i]) begin
            pri_hit = 1'b1;
            pri_ch  = CH_W'(i);
         end
      end
   end

   assign p_rd = pri_hit & ~rd_n;
   assign p_wr = pri_hit & ~wr_n;

   generate
      if (HAS_SINGLE) begin : g_dual
         logic sel;
         assign sel    = ~cs_n[0];
         assign rd_act = mode_strobe ? p_rd : (sel & wr_n);
         assign wr_act = mode_strobe ? p_wr : (sel & ~wr_n);
         assign chan   = mode_strobe ? pri_ch : cs_n[CH_W:1];
      end else begin : g_strobe_only
         assign rd_act = p_rd;
         assign wr_act = p_wr;
         assign chan   = pri_ch;
      end
   endgenerate

endmodule

// File: rtl/hbus_access_ctl.sv
module hbus_access_ctl #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned CH_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_act,
   input  logic              wr_act,
   input  logic [CH_W-1:0]   chan_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CH_W-1:0]   chan,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_pulse,
   output logic              rd_en,
   output logic              oe
);

   logic wr_q;
   logic rd_start;
   logic wr_track;

   assign rd_start = rd_act & ~oe;
   assign wr_track = wr_act & ~rd_act & ~oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe       <= 1'b0;
         wr_q     <= 1'b0;
         rd_en    <= 1'b0;
         wr_pulse <= 1'b0;
         chan     <= '0;
         reg_addr <= '0;
         wr_data  <= '0;
      end else begin
         oe       <= rd_act;
         wr_q     <= wr_act;
         rd_en    <= rd_start;
         wr_pulse <= wr_q & ~wr_act;
         if (rd_start) begin
            chan     <= chan_in;
            reg_addr <= addr_in;
         end else if (wr_track) begin
            chan     <= chan_in;
            reg_addr <= addr_in;
            wr_data  <= data_in;
         end
      end
   end

   // R8: a write pulse lasts one cycle
   a_r8_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |=> !wr_pulse);

   // R8: a read enable lasts one cycle
   a_r8_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);

   // R3: the bus is enabled whenever a read starts
   a_r3_oe_with_rd_en: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> oe);

   // R10: channel and address frozen during a read
   a_r10_hold_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && $past(oe)) |-> ($stable(chan) && $stable(reg_addr)));

endmodule

// File: rtl/hbus_decoder.sv
module hbus_decoder
   import hbus_pkg::*;
#(
   parameter int unsigned DATA_W      = HB_DEF_DATA_W,
   parameter int unsigned ADDR_W      = HB_DEF_ADDR_W,
   parameter int unsigned NUM_CH      = HB_DEF_NUM_CH,
   parameter int unsigned SYNC_STAGES = HB_DEF_SYNC,
   parameter bit          HAS_SINGLE  = 1'b1,
   localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_strobe,
   input  logic              rd_n_pin,
   input  logic              wr_n_pin,
   input  logic [NUM_CH-1:0] cs_n_pin,
   input  logic [ADDR_W-1:0] addr_pin,
   input  logic [DATA_W-1:0] bus_din,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_oe,
   output logic [CH_W-1:0]   chan,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              wr_pulse,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_en
);

   localparam int unsigned SW = 2 + NUM_CH + ADDR_W + DATA_W;
   localparam logic [SW-1:0] SYNC_RST = {2'b11, {NUM_CH{1'b1}}, {(ADDR_W + DATA_W){1'b0}}};

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hbus_decoder: SYNC_STAGES must be at least 2");
      end
      if (NUM_CH < 2) begin : g_bad_ch
         $error("hbus_decoder: NUM_CH must be at least 2");
      end
      if (HAS_SINGLE && (CH_W + 1 > NUM_CH)) begin : g_bad_single
         $error("hbus_decoder: too few select pins to carry channel bits");
      end
      if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("hbus_decoder: widths must be positive");
      end
   endgenerate

   logic [SW-1:0]     pins_raw;
   logic [SW-1:0]     pins_s;
   logic              rd_n_s;
   logic              wr_n_s;
   logic [NUM_CH-1:0] cs_n_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] data_s;

   assign pins_raw = {rd_n_pin, wr_n_pin, cs_n_pin, addr_pin, bus_din};
   assign {rd_n_s, wr_n_s, cs_n_s, addr_s, data_s} = pins_s;

   hbus_sync #(
      .W       (SW),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   logic            rd_act;
   logic            wr_act;
   logic [CH_W-1:0] chan_dec;

   hbus_chan_dec #(
      .NUM_CH     (NUM_CH),
      .CH_W       (CH_W),
      .HAS_SINGLE (HAS_SINGLE)
   ) u_dec (
      .mode_strobe (mode_strobe),
      .rd_n        (rd_n_s),
      .wr_n        (wr_n_s),
      .cs_n        (cs_n_s),
      .rd_act      (rd_act),
      .wr_act      (wr_act),
      .chan        (chan_dec)
   );

   hbus_access_ctl #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .CH_W   (CH_W)
   ) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_act   (rd_act),
      .wr_act   (wr_act),
      .chan_in  (chan_dec),
      .addr_in  (addr_s),
      .data_in  (data_s),
      .chan     (chan),
      .reg_addr (reg_addr),
      .wr_data  (wr_data),
      .wr_pulse (wr_pulse),
      .rd_en    (rd_en),
      .oe       (bus_oe)
   );

   assign bus_dout = bus_oe ? rd_data : '0;

endmodule

// File: tb/sim_hbus_decoder.sv
`timescale 1ns/1ps
module sim_hbus_decoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_strobe = 1'b1;
   logic       rd_n_pin = 1'b1;
   logic       wr_n_pin = 1'b1;
   logic [3:0] cs_n_pin = 4'hF;
   logic [2:0] addr_pin = '0;
   logic [7:0] bus_din = '0;
   logic [7:0] rd_data;
   logic [7:0] bus_dout;
   logic       bus_oe;
   logic [1:0] chan;
   logic [2:0] reg_addr;
   logic       wr_pulse;
   logic [7:0] wr_data;
   logic       rd_en;

   int checks = 0;
   int fails  = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   logic [1:0] wr_ch_s, rd_ch_s;
   logic [2:0] wr_a_s, rd_a_s;
   logic [7:0] wr_d_s;

   always #5 clk = ~clk;

   function automatic logic [7:0] model(logic [1:0] c, logic [2:0] a);
      return 8'h5A + ({6'd0, c} * 8'd37) + ({5'd0, a} * 8'd11);
   endfunction

   function automatic logic [1:0] lowest(logic [3:0] csn);
      for (int i = 3; i >= 0; i--) if (!csn[i]) lowest = 2'(i);
      if (csn == 4'hF) lowest = 2'd0;
   endfunction

   assign rd_data = model(chan, reg_addr);

   hbus_decoder u0 (
      .clk(clk), .rst_n(rst_n), .mode_strobe(mode_strobe),
      .rd_n_pin(rd_n_pin), .wr_n_pin(wr_n_pin), .cs_n_pin(cs_n_pin),
      .addr_pin(addr_pin), .bus_din(bus_din), .rd_data(rd_data),
      .bus_dout(bus_dout), .bus_oe(bus_oe), .chan(chan), .reg_addr(reg_addr),
      .wr_pulse(wr_pulse), .wr_data(wr_data), .rd_en(rd_en)
   );

   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (wr_pulse) begin
            wr_cnt++; wr_ch_s = chan; wr_a_s = reg_addr; wr_d_s = wr_data;
         end
         if (rd_en) begin
            rd_cnt++; rd_ch_s = chan; rd_a_s = reg_addr;
         end
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic idle_pins();
      rd_n_pin = 1'b1; wr_n_pin = 1'b1; cs_n_pin = 4'hF;
   endtask

   // R2 R4: strobe-style write
   task automatic s_write(logic [3:0] csn, logic [2:0] a, logic [7:0] d);
      wr_cnt = 0; rd_cnt = 0;
      cs_n_pin = csn; addr_pin = a; bus_din = d;
      cyc(1); wr_n_pin = 1'b0; cyc(4); wr_n_pin = 1'b1; cyc(2);
      cs_n_pin = 4'hF; bus_din = ~d; cyc(6);
      if (csn == 4'hF) begin
         chk("R4 no select no write", wr_cnt, 0);
      end else begin
         chk("R2 R8 write count", wr_cnt, 1);
         chk("R4 write channel", wr_ch_s, lowest(csn));
         chk("R2 write addr", wr_a_s, a);
         chk("R2 write data", wr_d_s, d);
      end
      chk("R2 no read on write", rd_cnt, 0);
   endtask

   // R3 R9 R10: strobe-style read
   task automatic s_read(logic [3:0] csn, logic [2:0] a, bit perturb);
      wr_cnt = 0; rd_cnt = 0;
      cs_n_pin = csn; addr_pin = a;
      cyc(1); rd_n_pin = 1'b0; cyc(6);
      if (csn == 4'hF) begin
         chk("R4 no select no oe", bus_oe, 0);
      end else begin
         chk("R3 oe during read", bus_oe, 1);
         chk("R4 read channel", chan, lowest(csn));
         chk("R3 read data", bus_dout, model(lowest(csn), a));
         if (perturb) begin
            addr_pin = ~a; cyc(4);
            chk("R10 addr held in read", reg_addr, a);
            chk("R10 chan held in read", chan, lowest(csn));
         end
      end
      rd_n_pin = 1'b1; cyc(4);
      chk("R9 oe released", bus_oe, 0);
      chk("R9 dout quiet", bus_dout, 0);
      cs_n_pin = 4'hF; cyc(4);
      chk("R8 read count", rd_cnt, (csn == 4'hF) ? 0 : 1);
      chk("R3 no write on read", wr_cnt, 0);
   endtask

   // R5 R7: single-select write (junk on ignored pins)
   task automatic m_write(logic [1:0] ch, logic [2:0] a, logic [7:0] d, logic jr, logic j3);
      wr_cnt = 0; rd_cnt = 0;
      cs_n_pin = {j3, ch[1], ch[0], 1'b1}; rd_n_pin = jr; wr_n_pin = 1'b0;
      addr_pin = a; bus_din = d;
      cyc(1); cs_n_pin[0] = 1'b0; cyc(2); rd_n_pin = ~jr; cs_n_pin[3] = ~j3; cyc(2);
      cs_n_pin[0] = 1'b1; cyc(2); bus_din = ~d; wr_n_pin = 1'b1; cyc(6);
      chk("R5 R8 write count", wr_cnt, 1);
      chk("R5 write channel", wr_ch_s, ch);
      chk("R5 write addr", wr_a_s, a);
      chk("R7 write data", wr_d_s, d);
      chk("R5 no read", rd_cnt, 0);
   endtask

   // R6 R9: single-select read
   task automatic m_read(logic [1:0] ch, logic [2:0] a, logic jr);
      wr_cnt = 0; rd_cnt = 0;
      cs_n_pin = {1'b1, ch[1], ch[0], 1'b1}; rd_n_pin = jr; wr_n_pin = 1'b1;
      addr_pin = a;
      cyc(1); cs_n_pin[0] = 1'b0; cyc(6);
      chk("R6 oe during read", bus_oe, 1);
      chk("R6 read channel", chan, ch);
      chk("R6 read data", bus_dout, model(ch, a));
      cs_n_pin[0] = 1'b1; cyc(4);
      chk("R9 oe released", bus_oe, 0);
      chk("R6 R8 read count", rd_cnt, 1);
      chk("R6 no write", wr_cnt, 0);
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h1C0DE));
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // R1 reset state
      chk("R1 wr_pulse", wr_pulse, 0);
      chk("R1 rd_en", rd_en, 0);
      chk("R1 oe", bus_oe, 0);
      chk("R1 chan", chan, 0);
      chk("R1 reg_addr", reg_addr, 0);
      chk("R1 wr_data", wr_data, 0);
      chk("R1 dout", bus_dout, 0);

      // strobe style directed
      s_write(4'b1110, 3'd5, 8'hA5);
      s_write(4'b0111, 3'd7, 8'h3C);
      s_write(4'b0101, 3'd1, 8'hFF);   // R4 priority: channel 1
      s_write(4'b1111, 3'd2, 8'h11);   // R4 none selected
      s_read(4'b1011, 3'd3, 1'b1);     // R10 perturbed address
      s_read(4'b0000, 3'd6, 1'b0);     // R4 all selected: channel 0
      s_read(4'b1111, 3'd0, 1'b0);
      for (int k = 0; k < 30; k++) begin
         s_write(4'($urandom), 3'($urandom), 8'($urandom));
         s_read(4'($urandom), 3'($urandom), 1'($urandom));
      end

      // single-select style
      idle_pins(); cyc(4);
      mode_strobe = 1'b0; cyc(4);
      // R7: ignored pins toggled with select high
      wr_cnt = 0; rd_cnt = 0;
      for (int k = 0; k < 6; k++) begin
         rd_n_pin = ~rd_n_pin; cs_n_pin[3] = ~cs_n_pin[3]; wr_n_pin = k[0]; cyc(3);
      end
      wr_n_pin = 1'b1; cyc(6);
      chk("R7 no write from ignored pins", wr_cnt, 0);
      chk("R7 no read from ignored pins", rd_cnt, 0);
      chk("R7 oe idle", bus_oe, 0);
      for (int c = 0; c < 4; c++) begin
         m_write(2'(c), 3'(c + 2), 8'(8'h40 + c), 1'b0, 1'b0);
         m_read(2'(c), 3'(7 - c), 1'b0);
      end
      for (int k = 0; k < 30; k++) begin
         m_write(2'($urandom), 3'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
         m_read(2'($urandom), 3'($urandom), 1'($urandom));
      end

      // back to strobe style
      idle_pins(); cyc(4);
      mode_strobe = 1'b1; cyc(4);
      s_write(4'b1101, 3'd4, 8'h5E);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule